// File: doc/BRIEF.md
# ADC Threshold Compare Event Unit

This block sits beside an analog-to-digital converter and classifies each finished conversion result against a pair of programmable limits, low and high. Two such limit pairs exist. A per-channel bank bit picks which pair a channel uses. For every result the block returns a two-bit range code and a two-bit crossing code, one cycle later, so that the surrounding logic can merge them into its result words.

Each channel remembers whether its previous result lay below its low limit. This history detects upward and downward crossings of the low limit. A per-channel event mode decides whether a channel raises its event flag when a result falls outside its limits, when a crossing occurs, or never. The flags are cleared by writing ones to them. A single interrupt line is the OR of all flags.

Top module: `adc_limit_watch`

## Requirements
- R1: Two limit pairs exist, pair 0 and pair 1. A write with `lim_we` stores `lim_wdata[15:4]` as the low (`lim_hi`=0) or high (`lim_hi`=1) limit of pair `lim_pair`. A write with `bank_we` loads `bank_wdata[ch]` as the pair select of channel ch, where 1 selects pair 1 and 0 selects pair 0.
- R2: The range code is 2 when the value is below the low limit, 3 when it is above the high limit, and 0 otherwise. A value equal to either limit counts as in range. Code 1 never appears.
- R3: The crossing code is 3 when the channel's previous result was below its low limit and the current one is not, and 2 in the opposite case. It is 0 when neither holds and 0 for a channel's first result after reset. Code 1 never appears.
- R4: Crossing history is kept separately per channel, so results on one channel do not affect crossings on another.
- R5: A result presented with `smp_vld` appears on `res_vld`, `res_chan`, `res_range` and `res_cross` exactly one clock later. `res_vld` is high for one cycle per input result, and `res_chan` holds its value while `res_vld` is low.
- R6: Channel ch has a 2-bit event mode at `mode_wdata[3+2*ch +: 2]`, loaded by `mode_we`. In mode 1 a result whose range code is not 0 sets flag ch. In mode 2 a result whose crossing code is not 0 sets flag ch. Modes 0 and 3 never set it. The flag is set in the same cycle that `res_vld` rises.
- R7: `evt_flags[11:0]` hold the per-channel flags. A `clr_we` write clears every flag whose bit in `clr_wdata[11:0]` is 1. If a set and a clear hit the same flag in the same cycle, the set wins.
- R8: `evt_irq` is high exactly when at least one flag is set.
- R9: A channel number of 12 or more gets range codes from pair 0 and a crossing code of 0. Such a result sets no flag and is not kept in any history.
- R10: After reset all flags, `evt_irq` and `res_vld` are 0, both pairs hold low 0 and high 4095, every bank bit is 0, every mode is 0, and no channel has history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Conversion result strobe |
| smp_val | input | 12 | Conversion result value |
| smp_chan | input | 4 | Channel of the result |
| lim_we | input | 1 | Limit write strobe |
| lim_pair | input | 1 | Limit pair written |
| lim_hi | input | 1 | 1 writes the high limit, 0 writes the low limit |
| lim_wdata | input | 32 | Limit write word, value in bits 15:4 |
| bank_we | input | 1 | Pair select write strobe |
| bank_wdata | input | 32 | Pair select per channel in bits 11:0 |
| mode_we | input | 1 | Event mode write strobe |
| mode_wdata | input | 32 | Event modes, channel ch at bits 3+2*ch+1:3+2*ch |
| clr_we | input | 1 | Flag clear strobe |
| clr_wdata | input | 32 | Write-one-to-clear mask in bits 11:0 |
| res_vld | output | 1 | Registered result strobe |
| res_chan | output | 4 | Channel of the registered result |
| res_range | output | 2 | Range code |
| res_cross | output | 2 | Crossing code |
| evt_flags | output | 12 | Per-channel event flags |
| evt_irq | output | 1 | OR of all event flags |

## Verification
The hardest state to reach is a set and a clear landing on the same flag in the same cycle, together with crossings that depend on history from several results earlier on the same channel while other channels are active in between. The stimulus builds history on two channels in interleaved order. It then issues a clear write in the very cycle that a result arrives on the channel whose flag is being cleared. Channel numbers above the implemented range are sent twice across the low limit to show that they keep no history.

// File: rtl/adc_lw_pkg.sv
package adc_lw_pkg;

  typedef enum logic [1:0] {
    RNG_IN   = 2'd0,
    RNG_RSVD = 2'd1,
    RNG_LOW  = 2'd2,
    RNG_HIGH = 2'd3
  } rng_e;

  typedef enum logic [1:0] {
    XC_NONE = 2'd0,
    XC_RSVD = 2'd1,
    XC_DOWN = 2'd2,
    XC_UP   = 2'd3
  } xc_e;

  typedef enum logic [1:0] {
    EM_OFF     = 2'd0,
    EM_OUTSIDE = 2'd1,
    EM_CROSS   = 2'd2,
    EM_SPARE   = 2'd3
  } emode_e;

  // below has priority so an inverted pair still yields a defined code
  function automatic rng_e range_of(input logic is_below, input logic is_above);
    if (is_below)      return RNG_LOW;
    else if (is_above) return RNG_HIGH;
    else               return RNG_IN;
  endfunction

  function automatic xc_e cross_of(input logic seen, input logic was_below,
                                   input logic is_below);
    if (!seen)                       return XC_NONE;
    else if (was_below && !is_below) return XC_UP;
    else if (!was_below && is_below) return XC_DOWN;
    else                             return XC_NONE;
  endfunction

  function automatic logic event_hit(input emode_e m, input rng_e r, input xc_e x);
    case (m)
      EM_OUTSIDE: return (r != RNG_IN);
      EM_CROSS:   return (x != XC_NONE);
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lw_limit_regs.sv
module lw_limit_regs
  import adc_lw_pkg::*;
#(
  parameter int unsigned NUM_CH    = 12,
  parameter int unsigned DW        = 12,
  parameter int unsigned VAL_LSB   = 4,
  parameter int unsigned MODE_BASE = 3,
  parameter int unsigned WW        = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lim_we,
  input  logic                 lim_pair,
  input  logic                 lim_hi,
  input  logic [WW-1:0]        lim_wdata,
  input  logic                 bank_we,
  input  logic [WW-1:0]        bank_wdata,
  input  logic                 mode_we,
  input  logic [WW-1:0]        mode_wdata,
  output logic [1:0][DW-1:0]   lo_q,
  output logic [1:0][DW-1:0]   hi_q,
  output logic [NUM_CH-1:0]    bank_q,
  output emode_e               mode_q [NUM_CH]
);

  localparam logic [DW-1:0] LO_RST = '0;
  localparam logic [DW-1:0] HI_RST = '1;

  for (genvar p = 0; p < 2; p++) begin : g_pair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[p] <= LO_RST;
        hi_q[p] <= HI_RST;
      end else if (lim_we && (lim_pair == 1'(p))) begin
        if (lim_hi) hi_q[p] <= lim_wdata[VAL_LSB +: DW];
        else        lo_q[p] <= lim_wdata[VAL_LSB +: DW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (bank_we) bank_q <= bank_wdata[NUM_CH-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q[c] <= EM_OFF;
      else if (mode_we) mode_q[c] <= emode_e'(mode_wdata[MODE_BASE + 2*c +: 2]);
    end
  end

endmodule

// File: rtl/lw_compare.sv
module lw_compare
  import adc_lw_pkg::*;
#(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned DW     = 12,
  parameter int unsigned CHW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic [DW-1:0]       smp_val,
  input  logic [CHW-1:0]      smp_chan,
  input  logic [1:0][DW-1:0]  lo_q,
  input  logic [1:0][DW-1:0]  hi_q,
  input  logic [NUM_CH-1:0]   bank_q,
  output logic [NUM_CH-1:0]   chan_hit,
  output rng_e                rng_now,
  output xc_e                 xc_now
);

  logic [NUM_CH-1:0] below_q;
  logic [NUM_CH-1:0] seen_q;
  logic              pair_sel;
  logic [DW-1:0]     lo_sel, hi_sel;
  logic              is_below, is_above;
  logic              was_below, seen;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
    assign chan_hit[c] = smp_vld && (smp_chan == CHW'(c));
  end

  // channels without a decode hit fall back to pair 0 and no history
  assign pair_sel  = |(chan_hit & bank_q);
  assign was_below = |(chan_hit & below_q);
  assign seen      = |(chan_hit & seen_q);

  assign lo_sel   = pair_sel ? lo_q[1] : lo_q[0];
  assign hi_sel   = pair_sel ? hi_q[1] : hi_q[0];
  assign is_below = smp_val < lo_sel;
  assign is_above = smp_val > hi_sel;

  assign rng_now = range_of(is_below, is_above);
  assign xc_now  = cross_of(seen, was_below, is_below);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        below_q[c] <= 1'b0;
        seen_q[c]  <= 1'b0;
      end else if (chan_hit[c]) begin
        below_q[c] <= is_below;
        seen_q[c]  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lw_flags.sv
module lw_flags
  import adc_lw_pkg::*;
#(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned WW     = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CH-1:0]  chan_hit,
  input  rng_e               rng_now,
  input  xc_e                xc_now,
  input  emode_e             mode_q [NUM_CH],
  input  logic               clr_we,
  input  logic [WW-1:0]      clr_wdata,
  output logic [NUM_CH-1:0]  set_req,
  output logic [NUM_CH-1:0]  flag_q
);

  logic [NUM_CH-1:0] clr_mask;
  assign clr_mask = clr_we ? clr_wdata[NUM_CH-1:0] : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
    assign set_req[c] = chan_hit[c] && event_hit(mode_q[c], rng_now, xc_now);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[c] <= 1'b0;
      else if (set_req[c]) flag_q[c] <= 1'b1;
      else if (clr_mask[c]) flag_q[c] <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_limit_watch.sv
module adc_limit_watch
  import adc_lw_pkg::*;
#(
  parameter int unsigned NUM_CH    = 12,
  parameter int unsigned DW        = 12,
  parameter int unsigned CHW       = 4,
  parameter int unsigned VAL_LSB   = 4,
  parameter int unsigned MODE_BASE = 3,
  parameter int unsigned WW        = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [DW-1:0]     smp_val,
  input  logic [CHW-1:0]    smp_chan,
  input  logic              lim_we,
  input  logic              lim_pair,
  input  logic              lim_hi,
  input  logic [WW-1:0]     lim_wdata,
  input  logic              bank_we,
  input  logic [WW-1:0]     bank_wdata,
  input  logic              mode_we,
  input  logic [WW-1:0]     mode_wdata,
  input  logic              clr_we,
  input  logic [WW-1:0]     clr_wdata,
  output logic              res_vld,
  output logic [CHW-1:0]    res_chan,
  output logic [1:0]        res_range,
  output logic [1:0]        res_cross,
  output logic [NUM_CH-1:0] evt_flags,
  output logic              evt_irq
);

  localparam int unsigned MODE_TOP = MODE_BASE + 2*NUM_CH;

  logic [1:0][DW-1:0] lo_q, hi_q;
  logic [NUM_CH-1:0]  bank_q;
  emode_e             mode_q [NUM_CH];
  logic [NUM_CH-1:0]  chan_hit;
  logic [NUM_CH-1:0]  set_req;
  rng_e               rng_now;
  xc_e                xc_now;

  initial begin
    if (MODE_TOP > WW) $error("event mode field exceeds write word");
    if (NUM_CH > (1 << CHW)) $error("channel number too narrow");
  end

  lw_limit_regs #(
    .NUM_CH(NUM_CH), .DW(DW), .VAL_LSB(VAL_LSB), .MODE_BASE(MODE_BASE), .WW(WW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .lim_we(lim_we), .lim_pair(lim_pair), .lim_hi(lim_hi), .lim_wdata(lim_wdata),
    .bank_we(bank_we), .bank_wdata(bank_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .lo_q(lo_q), .hi_q(hi_q), .bank_q(bank_q), .mode_q(mode_q)
  );

  lw_compare #(.NUM_CH(NUM_CH), .DW(DW), .CHW(CHW)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .smp_vld(smp_vld), .smp_val(smp_val), .smp_chan(smp_chan),
    .lo_q(lo_q), .hi_q(hi_q), .bank_q(bank_q),
    .chan_hit(chan_hit), .rng_now(rng_now), .xc_now(xc_now)
  );

  lw_flags #(.NUM_CH(NUM_CH), .WW(WW)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .chan_hit(chan_hit), .rng_now(rng_now), .xc_now(xc_now), .mode_q(mode_q),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .set_req(set_req), .flag_q(evt_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld   <= 1'b0;
      res_chan  <= '0;
      res_range <= RNG_IN;
      res_cross <= XC_NONE;
    end else begin
      res_vld <= smp_vld;
      if (smp_vld) begin
        res_chan  <= smp_chan;
        res_range <= rng_now;
        res_cross <= xc_now;
      end
    end
  end

  assign evt_irq = |evt_flags;

endmodule

// File: rtl/adc_limit_watch_chk.sv
module adc_limit_watch_chk #(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned CHW    = 4,
  parameter int unsigned WW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_we,
  input logic              res_vld,
  input logic [CHW-1:0]    res_chan,
  input logic [1:0]        res_range,
  input logic [1:0]        res_cross,
  input logic [NUM_CH-1:0] evt_flags,
  input logic              evt_irq
);

  // R2
  rsvd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (res_range != 2'd1));

  // R3
  rsvd_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (res_cross != 2'd1));

  // R3
  up_leaves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_cross == 2'd3) |-> (res_range != 2'd2));

  // R3
  down_enters_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_cross == 2'd2) |-> (res_range == 2'd2));

  // R5
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> $stable(res_chan));

  // R6
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_flags & ~$past(evt_flags))) |-> res_vld);

  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evt_irq) |-> $past(clr_we));

  // R9
  bad_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_chan >= CHW'(NUM_CH)) |-> (res_cross == 2'd0 && $stable(evt_flags)));

endmodule

bind adc_limit_watch adc_limit_watch_chk #(.NUM_CH(NUM_CH), .CHW(CHW), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_we(clr_we),
  .res_vld(res_vld), .res_chan(res_chan), .res_range(res_range),
  .res_cross(res_cross), .evt_flags(evt_flags), .evt_irq(evt_irq)
);

// File: tb/adc_limit_watch_bench.sv
`timescale 1ns/1ps
module adc_limit_watch_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_vld = 1'b0;
  logic [11:0] smp_val = '0;
  logic [3:0]  smp_chan = '0;
  logic        lim_we = 1'b0, lim_pair = 1'b0, lim_hi = 1'b0;
  logic [31:0] lim_wdata = '0;
  logic        bank_we = 1'b0;
  logic [31:0] bank_wdata = '0;
  logic        mode_we = 1'b0;
  logic [31:0] mode_wdata = '0;
  logic        clr_we = 1'b0;
  logic [31:0] clr_wdata = '0;
  logic        res_vld;
  logic [3:0]  res_chan;
  logic [1:0]  res_range, res_cross;
  logic [11:0] evt_flags;
  logic        evt_irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_limit_watch u_adc_limit_watch (
    .clk(clk), .rst_n(rst_n),
    .smp_vld(smp_vld), .smp_val(smp_val), .smp_chan(smp_chan),
    .lim_we(lim_we), .lim_pair(lim_pair), .lim_hi(lim_hi), .lim_wdata(lim_wdata),
    .bank_we(bank_we), .bank_wdata(bank_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .res_vld(res_vld), .res_chan(res_chan), .res_range(res_range),
    .res_cross(res_cross), .evt_flags(evt_flags), .evt_irq(evt_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_lim(input bit pair, input bit hi, input int v);
    @(negedge clk);
    lim_we = 1'b1; lim_pair = pair; lim_hi = hi; lim_wdata = 32'(v) << 4;
    @(negedge clk);
    lim_we = 1'b0;
  endtask

  task automatic set_bank(input logic [31:0] w);
    @(negedge clk); bank_we = 1'b1; bank_wdata = w;
    @(negedge clk); bank_we = 1'b0;
  endtask

  task automatic set_mode(input logic [31:0] w);
    @(negedge clk); mode_we = 1'b1; mode_wdata = w;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic clear(input logic [31:0] w);
    @(negedge clk); clr_we = 1'b1; clr_wdata = w;
    @(negedge clk); clr_we = 1'b0;
  endtask

  // one result; optional clear in the same cycle; outputs checked one edge later
  task automatic smp(input int ch, input int v, input logic [31:0] clr = '0);
    @(negedge clk);
    smp_vld = 1'b1; smp_chan = 4'(ch); smp_val = 12'(v);
    clr_we = (clr != 0); clr_wdata = clr;
    @(negedge clk);
    smp_vld = 1'b0; clr_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 res_vld after reset", int'(res_vld), 0);
    chk("R10 flags after reset", int'(evt_flags), 0);
    chk("R10 irq after reset", int'(evt_irq), 0);
    smp(0, 4095);
    chk("R10 default high limit 4095 in range", int'(res_range), 0);
    smp(1, 0);
    chk("R10 default low limit 0 in range", int'(res_range), 0);
    chk("R10 no crossing on first result", int'(res_cross), 0);
    chk("R10 mode 0 no flag", int'(evt_flags), 0);
  endtask

  task automatic t_range();
    set_lim(0, 0, 1000);
    set_lim(0, 1, 3000);
    smp(0, 500);
    chk("R5 res_vld one cycle later", int'(res_vld), 1);
    chk("R5 res_chan", int'(res_chan), 0);
    chk("R2 below low", int'(res_range), 2);
    @(negedge clk);
    chk("R5 res_vld single cycle", int'(res_vld), 0);
    smp(0, 1000); chk("R2 equal low in range", int'(res_range), 0);
    smp(0, 3000); chk("R2 equal high in range", int'(res_range), 0);
    smp(0, 3001); chk("R2 above high", int'(res_range), 3);
    smp(0, 999);  chk("R2 just below low", int'(res_range), 2);
  endtask

  task automatic t_bank();
    set_lim(1, 0, 100);
    set_lim(1, 1, 200);
    set_bank(32'h2);
    smp(1, 150); chk("R1 channel 1 uses pair 1 in range", int'(res_range), 0);
    smp(1, 250); chk("R1 channel 1 above pair 1 high", int'(res_range), 3);
    smp(0, 150); chk("R1 channel 0 uses pair 0", int'(res_range), 2);
  endtask

  task automatic t_cross();
    smp(2, 500);  chk("R3 first result no crossing", int'(res_cross), 0);
    smp(2, 1500); chk("R3 upward crossing", int'(res_cross), 3);
    smp(2, 1600); chk("R3 stays above no crossing", int'(res_cross), 0);
    smp(2, 400);  chk("R3 downward crossing", int'(res_cross), 2);
    smp(2, 300);  chk("R3 stays below no crossing", int'(res_cross), 0);
    smp(2, 1000); chk("R3 equal low counts as not below", int'(res_cross), 3);
  endtask

  task automatic t_indep();
    smp(3, 2000); chk("R4 channel 3 first result", int'(res_cross), 0);
    smp(3, 500);  chk("R4 channel 3 downward", int'(res_cross), 2);
    smp(2, 500);  chk("R4 channel 2 own history downward", int'(res_cross), 2);
    smp(3, 1500); chk("R4 channel 3 upward after channel 2", int'(res_cross), 3);
  endtask

  task automatic t_mode();
    set_mode((32'd1 << 11) | (32'd2 << 13) | (32'd3 << 17));
    smp(6, 500);  chk("R6 mode 0 no flag", int'(evt_flags), 0);
    smp(7, 500);
    smp(7, 1500); chk("R6 mode 3 crossing no flag", int'(evt_flags), 0);
    smp(4, 2000); chk("R6 mode 1 in range no flag", int'(evt_flags), 0);
    smp(4, 500);  chk("R6 mode 1 outside sets flag 4", int'(evt_flags), 12'h010);
    chk("R8 irq with one flag", int'(evt_irq), 1);
    smp(5, 500);  chk("R6 mode 2 first result no flag", int'(evt_flags), 12'h010);
    smp(5, 1500); chk("R6 mode 2 crossing sets flag 5", int'(evt_flags), 12'h030);
  endtask

  task automatic t_clear();
    clear(32'h010);
    chk("R7 clear only flag 4", int'(evt_flags), 12'h020);
    chk("R8 irq with flag 5 left", int'(evt_irq), 1);
    clear(32'h4000_0020);
    chk("R7 clear flag 5", int'(evt_flags), 0);
    chk("R8 irq low with no flags", int'(evt_irq), 0);
    smp(4, 500, 32'h010);
    chk("R7 set wins over clear", int'(evt_flags), 12'h010);
  endtask

  task automatic t_bad_chan();
    set_mode(32'hFFFF_FFFF);
    smp(13, 500);
    chk("R9 high channel reported", int'(res_chan), 13);
    chk("R9 high channel uses pair 0", int'(res_range), 2);
    chk("R9 high channel no flag", int'(evt_flags), 12'h010);
    smp(13, 1500);
    chk("R9 high channel keeps no history", int'(res_cross), 0);
    chk("R9 high channel flags unchanged", int'(evt_flags), 12'h010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_range();
    t_bank();
    t_cross();
    t_indep();
    t_mode();
    t_clear();
    t_bad_chan();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule